// File: doc/BRIEF.md
# Dual-Modulus Divider Counter Control

This block is the counting half of a dual-modulus prescaler divider. It runs on the output of a prescaler that divides by either N or N+1. Two down-counters set how many prescaler periods make up one output period, and how many of those periods use the larger modulus. The program counter sets the total cycle length. The swallow counter sets how many periods at the start of each cycle ask the prescaler for N+1. When the program counter reaches zero, the block raises a one-period divided-output pulse. On the following falling edge, both counters reload their seeds. With program seed P and swallow seed S (S no greater than P), one cycle spans P+1 prescaler periods. The overall division is therefore (P+1)·N + S input periods.

Neither counter has a dedicated decrement circuit. Each step adds the all-ones word, which is the two's-complement of one, to the stored count through a plain ripple adder. The sum is written back into the count register on the falling edge of the prescaler clock. The rising edge is thus left free for the prescaler to sample the modulus request. New seeds are captured by a synchronous load strobe into a holding register. They reach the counters only at the next reload, so a cycle already in progress is never changed.

Top module: `dmd_divider_ctrl`

## Requirements
- R1: A synchronous active-low reset, sampled on the falling edge, loads both counters and both held seeds with the parameter defaults RST_P and RST_S. While in reset, div_pulse reads 1 only if RST_P is 0, and mod_sel reads 1 only if RST_S is nonzero.
- R2: With held program seed P, consecutive divided-output pulses are exactly P+1 clock periods apart.
- R3: For P greater than 0, div_pulse is high for exactly one clock period per cycle, namely the last period of the cycle.
- R4: With swallow seed S and S ≤ P, mod_sel is 1 (divide by N+1) for the first S periods of a cycle. It is 0 (divide by N) for the remaining periods, including the pulse period.
- R5: A swallow seed of 0 keeps mod_sel at 0 for the whole cycle.
- R6: When seed_load is high at a falling edge, p_seed and s_seed are captured into the held seeds. They first govern the cycle that begins at the next reload. A load on the same edge as a reload takes effect only at the reload after that.
- R7: A program seed of 0 makes every period a reload, so div_pulse stays at 1.
- R8: The full counter range works: P = S = 2^WIDTH−1 yields a 2^WIDTH-period cycle with 2^WIDTH−1 periods at N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Strobe capturing new seeds into the holding register |
| p_seed | input | WIDTH | Program counter seed (cycle length minus one) |
| s_seed | input | WIDTH | Swallow counter seed (periods at N+1 per cycle) |
| mod_sel | output | 1 | Modulus request: 1 = divide by N+1, 0 = divide by N |
| div_pulse | output | 1 | One-period pulse marking the end of each divided cycle |

## Verification
The bench builds the block with WIDTH = 6, RST_P = 9 and RST_S = 3. At that width the all-ones seeds, whose 64-period cycles exercise every carry of the ripple adders, can be run in a few hundred clocks. The boundary seeds P = 0, S = 0 and S = P also fit alongside them. The small reset defaults make the first cycle after reset short and easy to tell apart from the loaded cycles. This shows that a reset also restores the held seeds.

// File: rtl/dmd_pkg.sv
// Shared definitions for the dual-modulus divider control.
// Assumes: the prescaler reads mod_sel as a single bit, 1 meaning N+1.
package dmd_pkg;

    // Modulus request encoding seen by the prescaler
    typedef enum logic {
        DIV_BY_N  = 1'b0,
        DIV_BY_N1 = 1'b1
    } dmd_mod_e;

endpackage

// File: rtl/dmd_ripple_adder.sv
// Plain ripple-carry adder, sum = a + b modulo 2^WIDTH.
// Assumes: carry-in is zero and the carry-out is not needed.
module dmd_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder sum bit per position
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
    end

    // Carry chain, stopping short of the unused carry-out
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_carry
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

endmodule

// File: rtl/dmd_down_counter.sv
// Seeded down-counter. It steps by adding the all-ones word (two's-complement
// of one) through a ripple adder, and writes the sum back on the falling clock
// edge. With HOLD_AT_ZERO set, it rests at zero instead of wrapping.
// Assumes: reload has priority over counting; reset is synchronous, active low.
module dmd_down_counter #(
    parameter int WIDTH        = 8,
    parameter int RST_VAL      = 0,
    parameter bit HOLD_AT_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] count,
    output logic             is_zero
);
    localparam logic [WIDTH-1:0] MINUS_ONE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] RST_WORD  = WIDTH'(RST_VAL);
    localparam logic [WIDTH-1:0] ONE       = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] dec_sum;
    logic [WIDTH-1:0] count_nxt;

    // Decrement path: stored value plus minus-one
    dmd_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .a  (count),
        .b  (MINUS_ONE),
        .sum(dec_sum)
    );

    assign is_zero = (count == '0);

    // Pick the next count: the seed on reload, else the stepped value
    if (HOLD_AT_ZERO) begin : g_hold
        always_comb begin
            if (reload)       count_nxt = seed;
            else if (is_zero) count_nxt = count;
            else              count_nxt = dec_sum;
        end
    end else begin : g_wrap
        always_comb begin
            if (reload) count_nxt = seed;
            else        count_nxt = dec_sum;
        end
    end

    // Falling-edge capture of the next count
    always_ff @(negedge clk) begin
        if (!rst_n) count <= RST_WORD;
        else        count <= count_nxt;
    end

    // A reload lands the seed in the count on the next edge
    assert_reload_seed_R2: assert property (@(negedge clk) disable iff (!rst_n)
        reload |=> (count == $past(seed)));

    // Away from reload and zero, each edge lowers the count by exactly one
    assert_step_down_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (!reload && !is_zero) |=> (count == ($past(count) - ONE)));

    if (HOLD_AT_ZERO) begin : g_hold_chk
        // A saturating counter sits at zero until the next reload
        assert_rest_at_zero_R5: assert property (@(negedge clk) disable iff (!rst_n)
            (!reload && is_zero) |=> is_zero);
    end

endmodule

// File: rtl/dmd_divider_ctrl.sv
// Counter control for a dual-modulus prescaler divider. The program counter
// sets the cycle length (seed + 1 prescaler periods). The swallow counter
// requests divide-by-N+1 for its first seed periods and rests at zero after
// them. A program count of zero raises div_pulse and reloads both counters
// from the held seeds on the next falling edge.
// Assumes: swallow seed <= program seed; all state moves on the falling edge.
module dmd_divider_ctrl
    import dmd_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int RST_P = 40,
    parameter int RST_S = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] p_seed,
    input  logic [WIDTH-1:0] s_seed,
    output logic             mod_sel,
    output logic             div_pulse
);
    localparam logic [WIDTH-1:0] RST_P_WORD = WIDTH'(RST_P);
    localparam logic [WIDTH-1:0] RST_S_WORD = WIDTH'(RST_S);

    logic [WIDTH-1:0] held_p;
    logic [WIDTH-1:0] held_s;
    logic [WIDTH-1:0] prog_cnt;
    logic [WIDTH-1:0] swal_cnt;
    logic             prog_zero;
    logic             swal_zero;
    logic             reload;
    dmd_mod_e         mod_req;

    // Holding register for seeds waiting for the next reload
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            held_p <= RST_P_WORD;
            held_s <= RST_S_WORD;
        end else if (seed_load) begin
            held_p <= p_seed;
            held_s <= s_seed;
        end
    end

    assign reload = prog_zero;

    // Program counter: wraps through the cycle, reloads at zero
    dmd_down_counter #(.WIDTH(WIDTH), .RST_VAL(RST_P), .HOLD_AT_ZERO(1'b0)) u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .seed   (held_p),
        .count  (prog_cnt),
        .is_zero(prog_zero)
    );

    // Swallow counter: runs down once per cycle, then rests at zero
    dmd_down_counter #(.WIDTH(WIDTH), .RST_VAL(RST_S), .HOLD_AT_ZERO(1'b1)) u_swal (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .seed   (held_s),
        .count  (swal_cnt),
        .is_zero(swal_zero)
    );

    // Modulus request from the swallow state
    always_comb begin
        mod_req = swal_zero ? DIV_BY_N : DIV_BY_N1;
    end

    assign mod_sel   = logic'(mod_req);
    assign div_pulse = prog_zero;

    // Held seeds change only through a load strobe
    assert_held_steady_R6: assert property (@(negedge clk) disable iff (!rst_n)
        !seed_load |=> ($stable(held_p) && $stable(held_s)));

    // With a nonzero program seed the pulse lasts a single period
    assert_single_pulse_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (div_pulse && (held_p != '0)) |=> !div_pulse);

    // The swallow phase has ended by the time the cycle closes
    assert_end_divide_n_R4: assert property (@(negedge clk) disable iff (!rst_n)
        div_pulse |-> (mod_sel == 1'b0));

    // A reload hands the program counter its held seed
    assert_cycle_start_R2: assert property (@(negedge clk) disable iff (!rst_n)
        div_pulse |=> (prog_cnt == $past(held_p)));

endmodule

// File: tb/sim_dmd_divider_ctrl.sv
`timescale 1ns/1ps
// Directed bench for dmd_divider_ctrl. Inputs are driven 1 ns after the rising
// edge and outputs are sampled on the rising edge; state moves on the falling edge.
module sim_dmd_divider_ctrl;
    localparam int W  = 6;
    localparam int RP = 9;
    localparam int RS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_load = 1'b0;
    logic [W-1:0] p_seed = '0;
    logic [W-1:0] s_seed = '0;
    logic         mod_sel;
    logic         div_pulse;

    logic s_ms;
    logic s_dp;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    dmd_divider_ctrl #(.WIDTH(W), .RST_P(RP), .RST_S(RS)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_load(seed_load),
        .p_seed   (p_seed),
        .s_seed   (s_seed),
        .mod_sel  (mod_sel),
        .div_pulse(div_pulse)
    );

    // Compare one value and report on mismatch
    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample on the rising edge, then step past it for driving
    task automatic step();
        @(posedge clk);
        s_ms = mod_sel;
        s_dp = div_pulse;
        #1;
    endtask

    // Advance until a divided pulse is sampled
    task automatic wait_pulse();
        for (int i = 0; i < 300; i++) begin
            step();
            if (s_dp) return;
        end
    endtask

    // Measure one cycle after a pulse sample, up to and including the next pulse
    task automatic measure(output int len, output int hi, output int extra, output int split);
        bit seen_low = 1'b0;
        len = 0; hi = 0; extra = 0; split = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            len++;
            if (s_ms) begin
                hi++;
                if (seen_low) split++;
            end else begin
                seen_low = 1'b1;
            end
            if (s_dp) return;
            extra += 0;
        end
    endtask

    // Load seeds, let them reach a reload, then check one full cycle
    task automatic run_seed(input int p, input int s, input string tag);
        int len, hi, extra, split;
        seed_load = 1'b1; p_seed = W'(p); s_seed = W'(s);
        step();
        seed_load = 1'b0;
        wait_pulse();
        measure(len, hi, extra, split);
        check({tag, " R2 cycle length"}, len, p + 1);
        check({tag, " R4 periods at N+1"}, hi, s);
        check({tag, " R4 N+1 periods lead the cycle"}, split, 0);
    endtask

    // Reset state and the first cycle out of reset
    task automatic t_reset();
        int len, hi, extra, split;
        rst_n = 1'b0;
        step(); step(); step();
        check("R1 div_pulse in reset", s_dp, (RP == 0) ? 1 : 0);
        check("R1 mod_sel in reset", s_ms, (RS != 0) ? 1 : 0);
        rst_n = 1'b1;
        measure(len, hi, extra, split);
        check("R1 first cycle length", len, RP);
        check("R1 first cycle N+1 periods", hi, RS - 1);
        measure(len, hi, extra, split);
        check("R1 default cycle length", len, RP + 1);
        check("R1 default N+1 periods", hi, RS);
    endtask

    // Single-period pulse for a nonzero program seed
    task automatic t_pulse_width();
        seed_load = 1'b1; p_seed = 6'd5; s_seed = 6'd2;
        step();
        seed_load = 1'b0;
        wait_pulse();
        wait_pulse();
        step();
        check("R3 pulse drops after one period", s_dp, 0);
        check("R3 new cycle opens at N+1", s_ms, 1);
    endtask

    // Load on the reload edge and during a cycle leaves that cycle alone
    task automatic t_deferred_load();
        int len, hi, extra, split;
        seed_load = 1'b1; p_seed = 6'd20; s_seed = 6'd5;
        step();
        seed_load = 1'b0;
        wait_pulse();
        measure(len, hi, extra, split);
        check("R6 base cycle length", len, 21);
        // last sample was a pulse: this load meets the reload edge
        seed_load = 1'b1; p_seed = 6'd10; s_seed = 6'd2;
        measure(len, hi, extra, split);
        seed_load = 1'b0;
        check("R6 old length kept", len, 21);
        check("R6 old N+1 count kept", hi, 5);
        measure(len, hi, extra, split);
        check("R6 new length applied", len, 11);
        check("R6 new N+1 count applied", hi, 2);
    endtask

    // Program seed zero: every period reloads
    task automatic t_zero_program();
        int len, hi, extra, split;
        run_seed(0, 0, "P0");
        for (int i = 0; i < 3; i++) begin
            step();
            check("R7 pulse held high", s_dp, 1);
            check("R7 mod_sel low", s_ms, 0);
        end
        measure(len, hi, extra, split);
        check("R7 cycle of one period", len, 1);
    endtask

    // Reset during a run restores the held seeds as well
    task automatic t_reset_restores();
        int len, hi, extra, split;
        seed_load = 1'b1; p_seed = 6'd40; s_seed = 6'd1;
        step();
        seed_load = 1'b0;
        step(); step();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check("R1 reset mid-run mod_sel", s_ms, (RS != 0) ? 1 : 0);
        measure(len, hi, extra, split);
        check("R1 reset mid-run first length", len, RP);
        measure(len, hi, extra, split);
        check("R1 held seed restored length", len, RP + 1);
        check("R1 held seed restored N+1", hi, RS);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        run_seed(20, 5, "basic");
        run_seed(12, 0, "R5 S0");
        run_seed(7, 7, "S=P");
        run_seed(1, 1, "short");
        run_seed(63, 63, "R8 full range");
        t_pulse_width();
        t_deferred_load();
        t_zero_program();
        t_reset_restores();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule